// File: doc/BRIEF.md
# Video Converter Digital Back End: Calibration Sequencer and Output Formatter

This block is the digital tail of a 10-bit video analog-to-digital converter. A raw 10-bit code arrives on every clock and moves through a fixed register pipeline to the output pins. The code is straight binary: code 0 stands for the bottom reference and code 1023 for the top. The block models the two calibration activities of the converter only as timing. A long startup calibration begins on a rising edge of `cal_rst` or a falling edge of the active-low enable `ce_n`. A short calibration begins on a falling edge of `cal_n` and, after a lag, freezes the output word for a few clocks while the comparator is busy.

A state machine sets the timing. Its states are ST_UNCAL (running, never calibrated), ST_STARTUP (startup calibration counting), ST_READY (normal conversion), ST_LAG (short calibration seen, output still live), ST_HOLD (output word frozen) and ST_STANDBY (chip disabled). Its transitions are: any state to ST_STANDBY while `ce_n` is high. Any state to ST_STARTUP on a start trigger. ST_STARTUP to ST_READY when the count expires. ST_READY to ST_LAG on a `cal_n` fall. ST_LAG to ST_HOLD after the lag. ST_HOLD to ST_READY after the hold. Standby has the highest priority, then a start trigger, then the per-state rule.

Formatting at the pins works as follows. Bits 8..0 are inverted by `linv` and bit 9 by `minv`. When `testmode` is low, a fixed alternating pattern replaces the data. When `oe_n` is high, the bus is released.

Top module: `vadc_backend`

## Requirements
- R1: With `testmode`=1 and `linv`=`minv`=0, after calibration, the word sampled on `raw_data` at edge k appears unchanged on `data_out` after edge k+3.
- R2: With `testmode`=1, `linv`=1 inverts bits 8..0 of the output word and `minv`=1 inverts bit 9 alone.
- R3: With `testmode`=0 the bus shows bit 9 = `minv` and, for bits i = 0..8, bit i = 1 for even i and 0 for odd i when `linv`=0 (value 0x155 on bits 8..0); `linv`=1 complements bits 8..0 (0x0AA).
- R4: `oe_n`=1 drives `data_oe` low and releases `data_out`; `oe_n`=0 drives `data_oe` high and drives the word.
- R5: A rising edge of `cal_rst` or a falling edge of `ce_n`, sampled at edge T, raises `cal_busy` after edges T .. T+STARTUP_CYCLES-1 with `data_valid` low; a new trigger restarts the count; `data_valid` rises after edge T+STARTUP_CYCLES+1.
- R6: Until the first startup calibration completes, bits 4..0 of the word are forced to 0 and `data_valid` stays low.
- R7: A `cal_n` fall detected at edge C in ST_READY raises `cal_busy` after edges C..C+9; after edges C+7..C+10 the output repeats the word shown after edge C+6, with `data_valid` low; after edge C+11 it shows the sample from edge C+8.
- R8: A `cal_n` fall detected outside ST_READY (before calibration, during startup, or during a running short calibration) has no effect on busy, valid or data.
- R9: While `ce_n` is high the block is in standby. `cal_busy` and `data_valid` are low, the output word is frozen from the second standby edge on, and a rising edge of `cal_rst` is ignored.
- R10: While `rst_n` is low, `cal_busy` and `data_valid` are 0 and the word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset of the digital logic |
| cal_rst | input | 1 | Rising edge restarts startup calibration |
| ce_n | input | 1 | High: standby; falling edge starts startup calibration |
| cal_n | input | 1 | Falling edge requests a short calibration |
| oe_n | input | 1 | High: output bus released |
| testmode | input | 1 | Low: fixed test pattern replaces data |
| linv | input | 1 | Inverts bits 8..0 |
| minv | input | 1 | Inverts bit 9 |
| raw_data | input | 10 | Raw converter code, straight binary |
| data_out | output | 10 | Formatted output bus |
| data_oe | output | 1 | High while the bus is driven |
| cal_busy | output | 1 | High while any calibration is in progress |
| data_valid | output | 1 | High when the word is a fresh calibrated sample |

## Verification
Each result has its own due cycle. Data is due three edges after the edge that sampled it. A start trigger takes effect at the very edge that samples it, and `cal_busy` falls exactly STARTUP_CYCLES edges later. The short-calibration freeze covers edges C+7 to C+10. Standby freezes the word from the second edge of standby. Formatting and output enable are combinational from the present control levels. The bench numbers every edge, drives inputs 2 ns after an edge and samples 2 ns after the next, so the expected value always comes from a raw code that is a known function of the edge number. Startup runs are shortened through the parameter so that every edge of each interval, the retrigger and the boundary edges on both sides are checked individually.

// File: rtl/vadc_pkg.sv
package vadc_pkg;

    typedef enum logic [2:0] {
        ST_UNCAL   = 3'd0,
        ST_STARTUP = 3'd1,
        ST_READY   = 3'd2,
        ST_LAG     = 3'd3,
        ST_HOLD    = 3'd4,
        ST_STANDBY = 3'd5
    } vadc_state_e;

    function automatic logic st_is_live(input vadc_state_e s);
        return (s == ST_READY) || (s == ST_LAG);
    endfunction

    function automatic logic st_is_busy(input vadc_state_e s);
        return (s == ST_STARTUP) || (s == ST_LAG) || (s == ST_HOLD);
    endfunction

endpackage

// File: rtl/vadc_edge_det.sv
module vadc_edge_det #(
    parameter int          N       = 3,
    parameter logic [N-1:0] RISE   = '0,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig,
    output logic [N-1:0] edge_o
);

    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
        end else begin
            prev_q <= sig;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_edge
        if (RISE[i]) begin : g_rise
            assign edge_o[i] = sig[i] & ~prev_q[i];
        end else begin : g_fall
            assign edge_o[i] = ~sig[i] & prev_q[i];
        end
    end

endmodule

// File: rtl/vadc_cal_fsm.sv
module vadc_cal_fsm
    import vadc_pkg::*;
#(
    parameter int STARTUP_CYCLES = 33000,
    parameter int CAL_LAG        = 7,
    parameter int CAL_HOLD       = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        standby,
    input  logic        start_trig,
    input  logic        cal_fall,
    output vadc_state_e state_q,
    output logic        cal_done_q,
    output logic        valid_q,
    output logic        busy,
    output logic        load_en,
    output logic        hold_en
);

    localparam int CNT_W = $clog2(STARTUP_CYCLES + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(STARTUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAG_LAST   = CNT_W'(CAL_LAG - 2);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(CAL_HOLD - 1);

    vadc_state_e      state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             done_d;
    logic             valid_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        done_d  = cal_done_q;
        if (standby) begin
            state_d = ST_STANDBY;
            cnt_d   = '0;
        end else if (start_trig) begin
            state_d = ST_STARTUP;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_UNCAL: begin
                    state_d = ST_UNCAL;
                end
                ST_STANDBY: begin
                    state_d = ST_STANDBY;
                end
                ST_STARTUP: begin
                    if (cnt_q == START_LAST) begin
                        state_d = ST_READY;
                        cnt_d   = '0;
                        done_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_READY: begin
                    if (cal_fall) begin
                        state_d = ST_LAG;
                        cnt_d   = '0;
                    end
                end
                ST_LAG: begin
                    if (cnt_q == LAG_LAST) begin
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt_q == HOLD_LAST) begin
                        state_d = ST_READY;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_UNCAL;
                    cnt_d   = '0;
                end
            endcase
        end
        valid_d = st_is_live(state_q) &&
                  (st_is_live(state_d) || (state_d == ST_HOLD));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_UNCAL;
            cnt_q      <= '0;
            cal_done_q <= 1'b0;
            valid_q    <= 1'b0;
        end else begin
            state_q    <= state_d;
            cnt_q      <= cnt_d;
            cal_done_q <= done_d;
            valid_q    <= valid_d;
        end
    end

    // outputs
    always_comb begin
        busy    = st_is_busy(state_q);
        load_en = (state_q != ST_STANDBY);
        hold_en = (state_q == ST_HOLD);
    end

endmodule

// File: rtl/vadc_sample_pipe.sv
module vadc_sample_pipe #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic         hold_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [W-1:0] src;
        logic         ld;
        if (i == 0) begin : g_first
            assign src = din;
        end else begin : g_next
            assign src = stg_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_last
            assign ld = load_en & ~hold_en;
        end else begin : g_mid
            assign ld = load_en;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[i] <= '0;
            end else if (ld) begin
                stg_q[i] <= src;
            end
        end
    end

    assign dout = stg_q[DEPTH-1];

endmodule

// File: rtl/vadc_out_fmt.sv
module vadc_out_fmt #(
    parameter int W     = 10,
    parameter int TRUNC = 5
) (
    input  logic [W-1:0] word,
    input  logic         cal_done,
    input  logic         testmode,
    input  logic         linv,
    input  logic         minv,
    output logic [W-1:0] fmt
);

    localparam logic [W-1:0] KEEP_MASK = {{(W-TRUNC){1'b1}}, {TRUNC{1'b0}}};

    logic [W-1:0] eff;
    logic [W-2:0] pat;

    for (genvar i = 0; i < W - 1; i++) begin : g_pat
        assign pat[i] = ((i % 2) == 0) ^ linv;
    end

    always_comb begin
        eff = cal_done ? word : (word & KEEP_MASK);
        if (testmode) begin
            fmt = {eff[W-1] ^ minv, eff[W-2:0] ^ {(W-1){linv}}};
        end else begin
            fmt = {minv, pat};
        end
    end

endmodule

// File: rtl/vadc_backend.sv
module vadc_backend
    import vadc_pkg::*;
#(
    parameter int W              = 10,
    parameter int PIPE_LAT       = 3,
    parameter int STARTUP_CYCLES = 33000,
    parameter int CAL_LAG        = 7,
    parameter int CAL_HOLD       = 4,
    parameter int TRUNC          = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cal_rst,
    input  logic         ce_n,
    input  logic         cal_n,
    input  logic         oe_n,
    input  logic         testmode,
    input  logic         linv,
    input  logic         minv,
    input  logic [W-1:0] raw_data,
    output logic [W-1:0] data_out,
    output logic         data_oe,
    output logic         cal_busy,
    output logic         data_valid
);

    localparam int DEPTH = PIPE_LAT + 1;

    logic [2:0]   edges;
    logic         start_trig;
    vadc_state_e  fsm_state;
    logic         cal_done;
    logic         load_en;
    logic         hold_en;
    logic [W-1:0] pipe_last;
    logic [W-1:0] fmt_word;

    // bit0: cal_rst rising, bit1: ce_n falling, bit2: cal_n falling
    vadc_edge_det #(
        .N      (3),
        .RISE   (3'b001),
        .RST_VAL(3'b001)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({cal_n, ce_n, cal_rst}),
        .edge_o(edges)
    );

    assign start_trig = edges[0] | edges[1];

    vadc_cal_fsm #(
        .STARTUP_CYCLES(STARTUP_CYCLES),
        .CAL_LAG       (CAL_LAG),
        .CAL_HOLD      (CAL_HOLD)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby   (ce_n),
        .start_trig(start_trig),
        .cal_fall  (edges[2]),
        .state_q   (fsm_state),
        .cal_done_q(cal_done),
        .valid_q   (data_valid),
        .busy      (cal_busy),
        .load_en   (load_en),
        .hold_en   (hold_en)
    );

    vadc_sample_pipe #(
        .W    (W),
        .DEPTH(DEPTH)
    ) u_pipe (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_en(load_en),
        .hold_en(hold_en),
        .din    (raw_data),
        .dout   (pipe_last)
    );

    vadc_out_fmt #(
        .W    (W),
        .TRUNC(TRUNC)
    ) u_fmt (
        .word    (pipe_last),
        .cal_done(cal_done),
        .testmode(testmode),
        .linv    (linv),
        .minv    (minv),
        .fmt     (fmt_word)
    );

    assign data_oe  = ~oe_n;
    assign data_out = oe_n ? {W{1'bz}} : fmt_word;

endmodule

// File: rtl/vadc_backend_chk.sv
module vadc_backend_chk
    import vadc_pkg::*;
#(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input vadc_state_e  state_q,
    input logic [W-1:0] last_q,
    input logic         data_valid,
    input logic         cal_done
);

    assert_startup_invalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP) |-> !data_valid);

    assert_uncal_invalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_done |-> !data_valid);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(last_q));

    assert_startup_no_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STARTUP) |=>
            (state_q == ST_STARTUP || state_q == ST_READY || state_q == ST_STANDBY));

    assert_standby_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STANDBY) |=> ($stable(last_q) && !data_valid));

endmodule

bind vadc_backend vadc_backend_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (fsm_state),
    .last_q    (pipe_last),
    .data_valid(data_valid),
    .cal_done  (cal_done)
);

// File: tb/vadc_backend_tb.sv
module vadc_backend_tb;

    localparam int CLK_PERIOD = 10;
    localparam int S          = 50;

    logic       clk = 1'b0;
    logic       rst_n, cal_rst, ce_n, cal_n, oe_n, testmode, linv, minv;
    logic [9:0] raw_data;
    wire  [9:0] data_out;
    logic       data_oe, cal_busy, data_valid;

    int n = 0;
    int vectors = 0;
    int errs = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vadc_backend #(.STARTUP_CYCLES(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .cal_rst(cal_rst), .ce_n(ce_n), .cal_n(cal_n),
        .oe_n(oe_n), .testmode(testmode), .linv(linv), .minv(minv),
        .raw_data(raw_data), .data_out(data_out), .data_oe(data_oe),
        .cal_busy(cal_busy), .data_valid(data_valid)
    );

    // raw code sampled at edge e
    function automatic logic [9:0] pat(input int e);
        return 10'((e * 389 + 7) & 1023);
    endfunction

    function automatic logic [9:0] fmt(input logic [9:0] w, input logic tm, li, mi);
        if (tm) return {w[9] ^ mi, w[8:0] ^ {9{li}}};
        return {mi, li ? 9'h0AA : 9'h155};
    endfunction

    task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s edge=%0d actual=%h expected=%h", req, n, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        n++;
        #2;
        raw_data = pat(n + 1);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            errs++;
            $display("FAIL watchdog edge=%0d actual=hung expected=done", n);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
            $finish;
        end
    end

    initial begin
        int t0, end_e, c0, s0, f0;
        rst_n = 0; cal_rst = 0; ce_n = 0; cal_n = 1; oe_n = 0;
        testmode = 1; linv = 0; minv = 0; raw_data = pat(1);

        // R10: reset state
        repeat (3) cyc();
        chk("R10 busy", 10'(cal_busy), 10'd0);
        chk("R10 valid", 10'(data_valid), 10'd0);
        chk("R10 word", data_out, 10'd0);
        chk("R4 oe", 10'(data_oe), 10'd1);
        rst_n = 1;

        // R6 uncalibrated truncation, R8 cal fall ignored before calibration
        while (n < 14) begin
            cyc();
            if (n >= 7) begin
                chk("R6 trunc", data_out, pat(n - 3) & 10'h3E0);
                chk("R6 valid", 10'(data_valid), 10'd0);
                chk("R8 busy", 10'(cal_busy), 10'd0);
            end
            if (n == 8) cal_n = 0;
            if (n == 10) cal_n = 1;
        end

        // R5 startup by cal_rst rise, with retrigger; R8 cal fall ignored in startup
        cal_rst = 1;
        t0 = n + 1;
        end_e = t0 + S;
        while (n < end_e + 3) begin
            cyc();
            chk("R5 busy", 10'(cal_busy), 10'(n < end_e));
            chk("R5 valid", 10'(data_valid), 10'(n > end_e));
            chk("R6 word", data_out, (n >= end_e) ? pat(n - 3) : (pat(n - 3) & 10'h3E0));
            if (n == t0 + 20) cal_rst = 0;
            if (n == t0 + 21) begin
                cal_rst = 1;
                end_e = t0 + 22 + S;
            end
            if (n == t0 + 5) cal_n = 0;
            if (n == t0 + 7) cal_n = 1;
        end

        // R1 R2 R3 R4: sweep all codes under all control mixes
        for (int k = 0; k < 1024; k++) begin
            cyc();
            if (oe_n) begin
                chk("R4 released", 10'(data_oe), 10'd0);
            end else begin
                chk("R4 driven", 10'(data_oe), 10'd1);
                chk(testmode ? ((linv | minv) ? "R2" : "R1") : "R3",
                    data_out, fmt(pat(n - 3), testmode, linv, minv));
            end
            chk("R1 valid", 10'(data_valid), 10'd1);
            begin
                int sel = (k + 1) % 16;
                testmode = (sel < 12);
                linv     = sel[0];
                minv     = sel[1];
                oe_n     = (sel == 5);
            end
        end
        testmode = 1; linv = 0; minv = 0; oe_n = 0;

        // R7 short calibration hold, R8 second fall during lag ignored
        cyc();
        cal_n = 0;
        c0 = n + 1;
        while (n < c0 + 16) begin
            cyc();
            chk("R7 busy", 10'(cal_busy), 10'(n <= c0 + 9));
            chk("R7 valid", 10'(data_valid), 10'(!(n >= c0 + 7 && n <= c0 + 10)));
            chk((n > c0 + 10) ? "R8 word" : "R7 word", data_out,
                (n >= c0 + 7 && n <= c0 + 10) ? pat(c0 + 3) : pat(n - 3));
            if (n == c0) cal_n = 1;
            if (n == c0 + 2) cal_n = 0;
            if (n == c0 + 4) cal_n = 1;
        end

        // R9 standby freeze, cal_rst rise ignored; then R5 start by ce_n fall
        ce_n = 1;
        s0 = n + 1;
        for (int k = 0; k < 7; k++) begin
            cyc();
            chk("R9 busy", 10'(cal_busy), 10'd0);
            chk("R9 valid", 10'(data_valid), 10'd0);
            chk("R9 word", data_out, pat(s0 - 3));
            if (k == 2) cal_rst = 0;
            if (k == 3) cal_rst = 1;
        end
        ce_n = 0;
        f0 = n + 1;
        while (n < f0 + S + 1) begin
            cyc();
            chk("R5 ce busy", 10'(cal_busy), 10'(n < f0 + S));
            chk("R5 ce valid", 10'(data_valid), 10'(n > f0 + S));
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule